// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a two-part logical address into a flat physical address. The two parts are a segment number and an offset within that segment. It holds a small segment table inside itself. Each table entry records the segment's starting physical address (its base), its length in bytes (its limit), a valid flag and three privilege bits for read, write and instruction fetch. A separate length register sets how many segment numbers the running program may use.

Software loads the table and the length register through a configuration write port. Lookups arrive on a request port, one per cycle. Each lookup carries a segment number, an offset and an access kind. One cycle later the block returns either the physical address or a fault code. The fault code names the first check that failed.

Two segment numbers may be loaded with identical base and limit. They then name one shared physical region, and both translate to the same addresses.

Top module: `seg_xlate_unit`

## Requirements
- R1: A response is valid (`rspValid`=1) exactly one cycle after a cycle with `reqValid`=1. In the cycle after a cycle without a request, `rspValid` is 0.
- R2: A segment number not strictly below the length register faults with code 1. This check has the highest priority and applies whatever the entry and access kind hold.
- R3: A segment in range whose entry has its valid flag at 0 faults with code 2. This takes precedence over the limit and privilege checks.
- R4: For an in-range, valid entry, an offset greater than or equal to the entry limit faults with code 3. This takes precedence over the privilege check. An offset of limit-1 is accepted.
- R5: The access kind is encoded as 0 = read, 1 = write, 2 = fetch and 3 = reserved. Read needs privilege bit 0, write needs bit 1 and fetch needs bit 2. A reserved kind, or a missing privilege, faults with code 4.
- R6: A lookup that passes every check responds with `rspFault`=0, `rspCode`=0 and `rspAddr` = base + offset, taken modulo 2^PA_W.
- R7: Any faulting response drives `rspAddr` to 0.
- R8: A table write or length write in the same cycle as a lookup is not seen by that lookup. It applies from the following cycle onward.
- R9: After reset, every entry is invalid, the length register is 0 and all response outputs are 0.
- R10: Two segment numbers loaded with the same base and limit return identical physical addresses for the same offset.
- R11: The limit is OFF_W+1 bits wide. A limit of 0 makes every offset fault with code 3. A limit of 2^OFF_W accepts every offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEntryWe | input | 1 | Write one table entry |
| cfgSegIdx | input | SEG_W | Entry to write |
| cfgBase | input | PA_W | Base physical address of the entry |
| cfgLimit | input | OFF_W+1 | Segment length in bytes |
| cfgValid | input | 1 | Valid flag of the entry |
| cfgPerm | input | 3 | Privileges: bit0 read, bit1 write, bit2 fetch |
| cfgLenWe | input | 1 | Write the length register |
| cfgLen | input | SEG_W+1 | Number of legal segment numbers |
| reqValid | input | 1 | Lookup request present |
| reqSeg | input | SEG_W | Segment number of the lookup |
| reqOff | input | OFF_W | Offset of the lookup |
| reqAcc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| rspValid | output | 1 | Response present |
| rspFault | output | 1 | Response is a fault |
| rspCode | output | 3 | 0 none, 1 segment range, 2 invalid, 3 limit, 4 privilege |
| rspAddr | output | PA_W | Translated physical address, 0 on fault |

## Verification
The checker watches these properties on every cycle:
- the one-cycle response timing;
- the zero address on every fault;
- the zero code on every success;
- the out-of-range and invalid-entry faults, predicted from a shadow of the configuration writes seen at the ports;
- the rule that a reserved access kind always faults.

Some behaviours come only from the bench's scenarios:
- the exact base-plus-offset sums, including wrap at the top of the physical space;
- the priority order between overlapping faults;
- the limit boundary at limit-1 and at limit;
- the same-cycle write ordering;
- the agreement of two aliased segments.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_SEG_RANGE = 3'd1,
    FLT_INVALID   = 3'd2,
    FLT_LIMIT     = 3'd3,
    FLT_PERM      = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  localparam int PERM_W   = 3;
  localparam int PERM_RD  = 0;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 2;

  typedef struct packed {
    logic   rspLoad;
    logic   rspFault;
    fault_e faultCode;
  } ctrl_strobe_t;

endpackage

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24,
  localparam int NSEG  = 1 << SEG_W,
  localparam int LEN_W = SEG_W + 1,
  localparam int LIM_W = OFF_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEntryWe,
  input  logic [SEG_W-1:0]   cfgSegIdx,
  input  logic [PA_W-1:0]    cfgBase,
  input  logic [LIM_W-1:0]   cfgLimit,
  input  logic               cfgValid,
  input  logic [PERM_W-1:0]  cfgPerm,
  input  logic               cfgLenWe,
  input  logic [LEN_W-1:0]   cfgLen,
  input  logic [SEG_W-1:0]   reqSeg,
  input  logic [OFF_W-1:0]   reqOff,
  input  ctrl_strobe_t       strb,
  output logic [LEN_W-1:0]   lenReg,
  output logic               entValid,
  output logic [LIM_W-1:0]   entLimit,
  output logic [PERM_W-1:0]  entPerm,
  output logic               rspValid,
  output logic               rspFault,
  output logic [2:0]         rspCode,
  output logic [PA_W-1:0]    rspAddr
);

  logic [PA_W-1:0]   baseArr  [NSEG];
  logic [LIM_W-1:0]  limitArr [NSEG];
  logic              validArr [NSEG];
  logic [PERM_W-1:0] permArr  [NSEG];

  // One register group per table entry, each with its own write decode.
  for (genvar e = 0; e < NSEG; e++) begin : g_entry
    logic hitWe;
    assign hitWe = cfgEntryWe && (cfgSegIdx == SEG_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseArr[e]  <= '0;
        limitArr[e] <= '0;
        validArr[e] <= 1'b0;
        permArr[e]  <= '0;
      end else if (hitWe) begin
        baseArr[e]  <= cfgBase;
        limitArr[e] <= cfgLimit;
        validArr[e] <= cfgValid;
        permArr[e]  <= cfgPerm;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         lenReg <= '0;
    else if (cfgLenWe) lenReg <= cfgLen;
  end

  // The lookup reads the entry contents from before this cycle's writes.
  logic [PA_W-1:0] entBase;
  always_comb begin
    entBase  = baseArr[reqSeg];
    entLimit = limitArr[reqSeg];
    entValid = validArr[reqSeg];
    entPerm  = permArr[reqSeg];
  end

  logic [PA_W-1:0] physSum;
  assign physSum = entBase + PA_W'(reqOff);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspCode  <= '0;
      rspAddr  <= '0;
    end else begin
      rspValid <= strb.rspLoad;
      if (strb.rspLoad) begin
        rspFault <= strb.rspFault;
        rspCode  <= strb.faultCode;
        rspAddr  <= strb.rspFault ? '0 : physSum;
      end else begin
        rspFault <= 1'b0;
        rspCode  <= '0;
        rspAddr  <= '0;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  localparam int LEN_W = SEG_W + 1,
  localparam int LIM_W = OFF_W + 1
) (
  input  logic               reqValid,
  input  logic [SEG_W-1:0]   reqSeg,
  input  logic [OFF_W-1:0]   reqOff,
  input  logic [1:0]         reqAcc,
  input  logic [LEN_W-1:0]   lenReg,
  input  logic               entValid,
  input  logic [LIM_W-1:0]   entLimit,
  input  logic [PERM_W-1:0]  entPerm,
  output ctrl_strobe_t       strb
);

  logic segOut, offOut, permMiss;

  assign segOut = {1'b0, reqSeg} >= lenReg;
  assign offOut = {1'b0, reqOff} >= entLimit;

  always_comb begin
    unique case (access_e'(reqAcc))
      ACC_READ:  permMiss = !entPerm[PERM_RD];
      ACC_WRITE: permMiss = !entPerm[PERM_WR];
      ACC_FETCH: permMiss = !entPerm[PERM_EX];
      default:   permMiss = 1'b1;
    endcase
  end

  // Fixed priority: range, then validity, then limit, then privilege.
  fault_e code;
  always_comb begin
    if (segOut)         code = FLT_SEG_RANGE;
    else if (!entValid) code = FLT_INVALID;
    else if (offOut)    code = FLT_LIMIT;
    else if (permMiss)  code = FLT_PERM;
    else                code = FLT_NONE;
  end

  always_comb begin
    strb.rspLoad   = reqValid;
    strb.rspFault  = reqValid && (code != FLT_NONE);
    strb.faultCode = reqValid ? code : FLT_NONE;
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEntryWe,
  input  logic [SEG_W-1:0]   cfgSegIdx,
  input  logic [PA_W-1:0]    cfgBase,
  input  logic [OFF_W:0]     cfgLimit,
  input  logic               cfgValid,
  input  logic [2:0]         cfgPerm,
  input  logic               cfgLenWe,
  input  logic [SEG_W:0]     cfgLen,
  input  logic               reqValid,
  input  logic [SEG_W-1:0]   reqSeg,
  input  logic [OFF_W-1:0]   reqOff,
  input  logic [1:0]         reqAcc,
  output logic               rspValid,
  output logic               rspFault,
  output logic [2:0]         rspCode,
  output logic [PA_W-1:0]    rspAddr
);

  ctrl_strobe_t        strb;
  logic [SEG_W:0]      lenReg;
  logic                entValid;
  logic [OFF_W:0]      entLimit;
  logic [PERM_W-1:0]   entPerm;

  seg_xlate_ctrl #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_ctrl (
    .reqValid (reqValid),
    .reqSeg   (reqSeg),
    .reqOff   (reqOff),
    .reqAcc   (reqAcc),
    .lenReg   (lenReg),
    .entValid (entValid),
    .entLimit (entLimit),
    .entPerm  (entPerm),
    .strb     (strb)
  );

  seg_xlate_dp #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgEntryWe (cfgEntryWe),
    .cfgSegIdx  (cfgSegIdx),
    .cfgBase    (cfgBase),
    .cfgLimit   (cfgLimit),
    .cfgValid   (cfgValid),
    .cfgPerm    (cfgPerm),
    .cfgLenWe   (cfgLenWe),
    .cfgLen     (cfgLen),
    .reqSeg     (reqSeg),
    .reqOff     (reqOff),
    .strb       (strb),
    .lenReg     (lenReg),
    .entValid   (entValid),
    .entLimit   (entLimit),
    .entPerm    (entPerm),
    .rspValid   (rspValid),
    .rspFault   (rspFault),
    .rspCode    (rspCode),
    .rspAddr    (rspAddr)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 4,
  parameter int PA_W  = 24,
  localparam int NSEG = 1 << SEG_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgEntryWe,
  input logic [SEG_W-1:0] cfgSegIdx,
  input logic             cfgValid,
  input logic             cfgLenWe,
  input logic [SEG_W:0]   cfgLen,
  input logic             reqValid,
  input logic [SEG_W-1:0] reqSeg,
  input logic [1:0]       reqAcc,
  input logic             rspValid,
  input logic             rspFault,
  input logic [2:0]       rspCode,
  input logic [PA_W-1:0]  rspAddr
);

  // Shadow of the configuration as seen at the ports.
  logic [SEG_W:0]  lenShadow;
  logic [NSEG-1:0] validShadow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenShadow   <= '0;
      validShadow <= '0;
    end else begin
      if (cfgLenWe)   lenShadow <= cfgLen;
      if (cfgEntryWe) validShadow[cfgSegIdx] <= cfgValid;
    end
  end

  logic inRange;
  assign inRange = {1'b0, reqSeg} < lenShadow;

  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  a_r2_seg_range: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !inRange) |=> (rspFault && rspCode == 3'd1));

  a_r3_invalid_entry: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && inRange && !validShadow[reqSeg]) |=> (rspFault && rspCode == 3'd2));

  a_r5_reserved_faults: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAcc == 2'd3) |=> rspFault);

  a_r6_ok_code_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> rspCode == 3'd0);

  a_r7_fault_addr_zero: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> rspAddr == '0);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspFault && rspCode == 3'd0 && rspAddr == '0));

endmodule

bind seg_xlate_unit seg_xlate_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgEntryWe (cfgEntryWe),
  .cfgSegIdx  (cfgSegIdx),
  .cfgValid   (cfgValid),
  .cfgLenWe   (cfgLenWe),
  .cfgLen     (cfgLen),
  .reqValid   (reqValid),
  .reqSeg     (reqSeg),
  .reqAcc     (reqAcc),
  .rspValid   (rspValid),
  .rspFault   (rspFault),
  .rspCode    (rspCode),
  .rspAddr    (rspAddr)
);

// File: tb/seg_xlate_unit_tb.sv
module seg_xlate_unit_tb;

  localparam int SEG_W = 4;
  localparam int OFF_W = 16;
  localparam int PA_W  = 24;

  logic             clk = 1'b0;
  logic             rstN;
  logic             cfgEntryWe;
  logic [SEG_W-1:0] cfgSegIdx;
  logic [PA_W-1:0]  cfgBase;
  logic [OFF_W:0]   cfgLimit;
  logic             cfgValid;
  logic [2:0]       cfgPerm;
  logic             cfgLenWe;
  logic [SEG_W:0]   cfgLen;
  logic             reqValid;
  logic [SEG_W-1:0] reqSeg;
  logic [OFF_W-1:0] reqOff;
  logic [1:0]       reqAcc;
  logic             rspValid;
  logic             rspFault;
  logic [2:0]       rspCode;
  logic [PA_W-1:0]  rspAddr;

  always #2 clk = ~clk;

  seg_xlate_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_dut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  seg;
    logic [15:0] off;
    logic [1:0]  acc;
    logic [2:0]  code;
    logic [23:0] addr;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{8'd6,  4'd0,  16'h0010, 2'd0, 3'd0, 24'h100010}, // R6 read in code segment
    '{8'd4,  4'd0,  16'h0FFF, 2'd2, 3'd0, 24'h100FFF}, // R4 last legal offset, fetch
    '{8'd4,  4'd0,  16'h1000, 2'd0, 3'd3, 24'h000000}, // R4 offset equal to limit
    '{8'd5,  4'd0,  16'h0004, 2'd1, 3'd4, 24'h000000}, // R5 write to code segment
    '{8'd6,  4'd1,  16'h07FF, 2'd1, 3'd0, 24'h2007FF}, // R6 write to data segment
    '{8'd5,  4'd1,  16'h0003, 2'd2, 3'd4, 24'h000000}, // R5 fetch from data segment
    '{8'd10, 4'd2,  16'h07FF, 2'd0, 3'd0, 24'h2007FF}, // R10 alias gives same address
    '{8'd3,  4'd3,  16'h0000, 2'd0, 3'd2, 24'h000000}, // R3 invalid entry
    '{8'd3,  4'd3,  16'h0200, 2'd1, 3'd2, 24'h000000}, // R3 invalid beats limit
    '{8'd11, 4'd4,  16'hFFFF, 2'd0, 3'd0, 24'h00FFEF}, // R11 full limit, R6 wrap
    '{8'd11, 4'd5,  16'h0000, 2'd0, 3'd3, 24'h000000}, // R11 zero limit
    '{8'd2,  4'd6,  16'h0000, 2'd0, 3'd1, 24'h000000}, // R2 segment at length
    '{8'd2,  4'd15, 16'hFFFF, 2'd3, 3'd1, 24'h000000}, // R2 range beats everything
    '{8'd5,  4'd1,  16'h0000, 2'd3, 3'd4, 24'h000000}, // R5 reserved access kind
    '{8'd4,  4'd0,  16'h1000, 2'd1, 3'd3, 24'h000000}  // R4 limit beats privilege
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeEntry(input logic [SEG_W-1:0] idx, input logic [PA_W-1:0] base,
                            input logic [OFF_W:0] lim, input logic vld, input logic [2:0] perm);
    @(negedge clk);
    cfgEntryWe = 1'b1; cfgSegIdx = idx; cfgBase = base;
    cfgLimit = lim; cfgValid = vld; cfgPerm = perm;
    @(posedge clk); #1;
    cfgEntryWe = 1'b0;
  endtask

  task automatic writeLen(input logic [SEG_W:0] len);
    @(negedge clk);
    cfgLenWe = 1'b1; cfgLen = len;
    @(posedge clk); #1;
    cfgLenWe = 1'b0;
  endtask

  // Drives one lookup; the response is sampled 1 ns after the capturing edge.
  task automatic lookup(input logic [SEG_W-1:0] seg, input logic [OFF_W-1:0] off,
                        input logic [1:0] acc);
    @(negedge clk);
    reqValid = 1'b1; reqSeg = seg; reqOff = off; reqAcc = acc;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic expectRsp(input string tag, input logic [2:0] code, input logic [23:0] addr);
    check({tag, " valid"}, 32'(rspValid), 32'(1'b1));
    check({tag, " fault"}, 32'(rspFault), 32'(code != 3'd0));
    check({tag, " code"},  32'(rspCode),  32'(code));
    check({tag, " addr"},  32'(rspAddr),  32'(addr));
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

  initial begin
    rstN = 1'b0; cfgEntryWe = 1'b0; cfgSegIdx = '0; cfgBase = '0; cfgLimit = '0;
    cfgValid = 1'b0; cfgPerm = '0; cfgLenWe = 1'b0; cfgLen = '0;
    reqValid = 1'b0; reqSeg = '0; reqOff = '0; reqAcc = '0;
    repeat (4) @(posedge clk);
    #1;
    // R9: outputs quiet during reset
    check("R9 rspValid in reset", 32'(rspValid), 0);
    check("R9 rspAddr in reset",  32'(rspAddr), 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R9 rspFault after reset", 32'(rspFault), 0);
    check("R9 rspCode after reset",  32'(rspCode), 0);
    // R9: length 0 after reset, so segment 0 is out of range
    lookup(4'd0, 16'd0, 2'd0);
    expectRsp("R9 length zero after reset", 3'd1, 24'h0);
    // R9: entry invalid after reset once the length allows it
    writeLen(5'd1);
    lookup(4'd0, 16'd0, 2'd0);
    expectRsp("R9 entry invalid after reset", 3'd2, 24'h0);

    // Table used by the vector walk
    writeEntry(4'd0, 24'h100000, 17'h01000, 1'b1, 3'b101);
    writeEntry(4'd1, 24'h200000, 17'h00800, 1'b1, 3'b011);
    writeEntry(4'd2, 24'h200000, 17'h00800, 1'b1, 3'b011);
    writeEntry(4'd3, 24'h300000, 17'h00100, 1'b0, 3'b111);
    writeEntry(4'd4, 24'hFFFFF0, 17'h10000, 1'b1, 3'b111);
    writeEntry(4'd5, 24'h400000, 17'h00000, 1'b1, 3'b111);
    writeEntry(4'd6, 24'h500000, 17'h00100, 1'b1, 3'b111);
    writeLen(5'd6);

    for (int i = 0; i < NVEC; i++) begin
      lookup(VECS[i].seg, VECS[i].off, VECS[i].acc);
      expectRsp($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].code, VECS[i].addr);
    end

    // R1: no request gives no response in the next cycle
    @(negedge clk); @(posedge clk); #1;
    check("R1 idle cycle rspValid", 32'(rspValid), 0);

    // R1: back-to-back lookups respond on consecutive cycles
    @(negedge clk);
    reqValid = 1'b1; reqSeg = 4'd0; reqOff = 16'h0001; reqAcc = 2'd0;
    @(posedge clk); #1;
    check("R1 back-to-back first addr", 32'(rspAddr), 32'h100001);
    reqSeg = 4'd1; reqOff = 16'h0002; reqAcc = 2'd1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    check("R1 back-to-back second addr", 32'(rspAddr), 32'h200002);

    // R8: entry rewrite in the same cycle as a lookup of that entry
    @(negedge clk);
    cfgEntryWe = 1'b1; cfgSegIdx = 4'd1; cfgBase = 24'h210000;
    cfgLimit = 17'h00800; cfgValid = 1'b1; cfgPerm = 3'b011;
    reqValid = 1'b1; reqSeg = 4'd1; reqOff = 16'h0010; reqAcc = 2'd0;
    @(posedge clk); #1;
    cfgEntryWe = 1'b0; reqValid = 1'b0;
    expectRsp("R8 lookup sees old base", 3'd0, 24'h200010);
    lookup(4'd1, 16'h0010, 2'd0);
    expectRsp("R8 next lookup sees new base", 3'd0, 24'h210010);

    // R8: length write in the same cycle as a lookup at the old bound
    @(negedge clk);
    cfgLenWe = 1'b1; cfgLen = 5'd7;
    reqValid = 1'b1; reqSeg = 4'd6; reqOff = 16'h0020; reqAcc = 2'd1;
    @(posedge clk); #1;
    cfgLenWe = 1'b0; reqValid = 1'b0;
    expectRsp("R8 lookup sees old length", 3'd1, 24'h0);
    lookup(4'd6, 16'h0020, 2'd1);
    expectRsp("R8 next lookup sees new length", 3'd0, 24'h500020);

    // R10: aliased pair still agrees after segment 1 moved; reload alias
    writeEntry(4'd2, 24'h210000, 17'h00800, 1'b1, 3'b011);
    lookup(4'd1, 16'h0123, 2'd1);
    expectRsp("R10 alias first", 3'd0, 24'h210123);
    lookup(4'd2, 16'h0123, 2'd1);
    expectRsp("R10 alias second", 3'd0, 24'h210123);

    // R3: invalidating a previously valid entry
    writeEntry(4'd0, 24'h100000, 17'h01000, 1'b0, 3'b101);
    lookup(4'd0, 16'h0001, 2'd0);
    expectRsp("R3 entry cleared", 3'd2, 24'h0);

    finished = 1'b1;
    finish();
  end

endmodule